// File: doc/BRIEF.md
# Multi-Length Pseudo-Random Sequence and Number Generator

This block produces a pseudo-random bit stream from one shift-register bank. The bank can act as one of six maximal-length Fibonacci shift registers, of length 9, 15, 16, 20, 21 or 23 stages, or as an 8-stage Galois register. A mode code selects the arrangement. Each enabled clock advances the register by one step. The stage shifted out is presented as the serial bit. The low eight stages are presented as a parallel number, and in the 9-stage mode a ninth bit is added.

A mode and a seed are taken together, either at reset or on a load strobe. A seed that is zero after it is cut to the selected length is replaced by all ones, so the register never locks up. The stages above the selected length are cleared. A one-cycle pulse marks each return of the register to the seed it started from, which marks the end of each period.

Top module: `prbs_multi_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the register is loaded with all ones over the length that `mode_i` selects, that mode is taken, and `wrap_o` is low after the edge.
- R2: Mode codes 1 to 6 give Fibonacci lengths 9, 15, 16, 20, 21 and 23, and code 7 behaves as code 1. One step shifts every stage down by one. The XOR of the tap stages enters the top stage (length−1). The taps are: 9 → stages 4,0; 15 → 1,0; 16 → 5,3,2,0; 20 → 3,0; 21 → 2,0; 23 → 5,0. `bit_o` always shows stage 0.
- R3: Mode code 0 is an 8-stage Galois register. One step shifts down by one. The old stage 0 goes into stage 7 and is also XORed into stages 5, 4 and 3 (toggle mask 0xB8).
- R4: When `en_i` and `load_i` are both low, the register and the outputs hold their values and `wrap_o` is low.
- R5: When `load_i` is high and `rst` is low, the register takes `seed_i` masked to the selected length, and a masked value of zero becomes all ones. A load takes priority over `en_i`.
- R6: A change on `mode_i` has no effect unless it comes with a reset or a load.
- R7: `num_o[7:0]` shows stages 7..0. `num_o[8]` shows stage 8 in modes 1 and 7 and is zero in all other modes.
- R8: `wrap_o` is high for the one cycle after an enabled step that brings the register back to its seed. The periods are 255, 511, 32767 and 65535 for codes 0, 1, 2 and 3.
- R9: The register never holds all zeros once reset has been applied.
- R10: Stages at or above the selected length stay zero, so feedback always enters at stage length−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance one step |
| load_i | input | 1 | Take `mode_i` and `seed_i` |
| mode_i | input | 3 | Mode code (see R2, R3) |
| seed_i | input | 23 | Seed value, masked to the selected length |
| bit_o | output | 1 | Serial output, stage 0 |
| num_o | output | 9 | Parallel number from the low stages |
| wrap_o | output | 1 | End-of-period pulse |

## Verification
Directed loads use a zero seed, a seed that becomes zero only after masking, and a load together with enable. These separate the masking and lock-up rules from the load priority. Full periods are run in the Galois, 9, 15 and 16-stage modes, and the wrap pulse must appear on the exact final step and never before it, which shows that each tap set is maximal. A long random phase mixes enable gaps, loads in every mode code (including the reserved one), rare resets, and `mode_i` changes without a load. It is compared step by step against a reference model. This catches wrong taps, a wrong feedback stage, a leaking mode switch and a wrong ninth number bit.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  localparam int MENU_MAX_LEN = 23;
  localparam int MODE_W       = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_GAL8 = 3'd0,
    MODE_F9   = 3'd1,
    MODE_F15  = 3'd2,
    MODE_F16  = 3'd3,
    MODE_F20  = 3'd4,
    MODE_F21  = 3'd5,
    MODE_F23  = 3'd6,
    MODE_RSV  = 3'd7
  } prbs_mode_e;

  localparam logic [MENU_MAX_LEN-1:0] GAL_TOGGLE = 23'h0000B8;

  function automatic int unsigned mode_len(logic [MODE_W-1:0] m);
    case (prbs_mode_e'(m))
      MODE_GAL8: return 8;
      MODE_F15:  return 15;
      MODE_F16:  return 16;
      MODE_F20:  return 20;
      MODE_F21:  return 21;
      MODE_F23:  return 23;
      default:   return 9;
    endcase
  endfunction

  function automatic logic [MENU_MAX_LEN-1:0] len_mask(logic [MODE_W-1:0] m);
    logic [MENU_MAX_LEN-1:0] v;
    for (int i = 0; i < MENU_MAX_LEN; i++) v[i] = (i < int'(mode_len(m)));
    return v;
  endfunction

  function automatic logic [MENU_MAX_LEN-1:0] top_stage(logic [MODE_W-1:0] m);
    logic [MENU_MAX_LEN-1:0] v;
    for (int i = 0; i < MENU_MAX_LEN; i++) v[i] = (i == int'(mode_len(m)) - 1);
    return v;
  endfunction

  function automatic logic [MENU_MAX_LEN-1:0] fib_taps(logic [MODE_W-1:0] m);
    case (prbs_mode_e'(m))
      MODE_F15:  return 23'h000003;
      MODE_F16:  return 23'h00002D;
      MODE_F20:  return 23'h000009;
      MODE_F21:  return 23'h000005;
      MODE_F23:  return 23'h000021;
      MODE_GAL8: return 23'h000000;
      default:   return 23'h000011;
    endcase
  endfunction

endpackage

// File: rtl/prbs_seed_cond.sv
module prbs_seed_cond
  import prbs_gen_pkg::*;
#(
  parameter int STAGES = MENU_MAX_LEN
) (
  input  logic [STAGES-1:0] seed_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [STAGES-1:0] seed_o
);

  logic [STAGES-1:0] keep;
  logic [STAGES-1:0] masked;

  always_comb begin
    keep   = STAGES'(len_mask(mode_i));
    masked = seed_i & keep;
    // a zero seed would lock the register, substitute all ones
    seed_o = (masked == '0) ? keep : masked;
  end

endmodule

// File: rtl/prbs_step.sv
module prbs_step
  import prbs_gen_pkg::*;
#(
  parameter int STAGES = MENU_MAX_LEN
) (
  input  logic [STAGES-1:0] state_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [STAGES-1:0] nxt_o
);

  logic [STAGES-1:0] shifted;
  logic [STAGES-1:0] taps;
  logic [STAGES-1:0] entry;
  logic              fb;

  for (genvar i = 0; i < STAGES; i++) begin : g_shift
    if (i == STAGES - 1) begin : g_top
      assign shifted[i] = 1'b0;
    end else begin : g_mid
      assign shifted[i] = state_i[i+1];
    end
  end

  always_comb begin
    taps  = STAGES'(fib_taps(mode_i));
    entry = STAGES'(top_stage(mode_i));
    fb    = ^(state_i & taps);
    if (prbs_mode_e'(mode_i) == MODE_GAL8) begin
      nxt_o = shifted ^ ({STAGES{state_i[0]}} & STAGES'(GAL_TOGGLE));
    end else begin
      nxt_o = shifted | (fb ? entry : '0);
    end
  end

endmodule

// File: rtl/prbs_multi_gen.sv
module prbs_multi_gen
  import prbs_gen_pkg::*;
#(
  parameter int STAGES = MENU_MAX_LEN,
  parameter int NUM_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [STAGES-1:0] seed_i,
  output logic              bit_o,
  output logic [NUM_W-1:0]  num_o,
  output logic              wrap_o
);

  localparam int BYTE_W = NUM_W - 1;

  logic [MODE_W-1:0] mode_q;
  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] seed_q;
  logic              wrap_q;
  logic [STAGES-1:0] seed_src;
  logic [STAGES-1:0] seed_ok;
  logic [STAGES-1:0] nxt;
  logic              ninth_on;

  assign seed_src = rst ? '0 : seed_i;

  prbs_seed_cond #(.STAGES(STAGES)) u_seed (
    .seed_i (seed_src),
    .mode_i (mode_i),
    .seed_o (seed_ok)
  );

  prbs_step #(.STAGES(STAGES)) u_step (
    .state_i (state_q),
    .mode_i  (mode_q),
    .nxt_o   (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      mode_q  <= mode_i;
      state_q <= seed_ok;
      seed_q  <= seed_ok;
      wrap_q  <= 1'b0;
    end else if (en_i) begin
      state_q <= nxt;
      wrap_q  <= (nxt == seed_q);
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  assign ninth_on = (prbs_mode_e'(mode_q) == MODE_F9) || (prbs_mode_e'(mode_q) == MODE_RSV);

  assign bit_o              = state_q[0];
  assign num_o[BYTE_W-1:0]  = state_q[BYTE_W-1:0];
  assign num_o[BYTE_W]      = ninth_on & state_q[BYTE_W];
  assign wrap_o             = wrap_q;

endmodule

// File: rtl/prbs_multi_gen_chk.sv
module prbs_multi_gen_chk
  import prbs_gen_pkg::*;
#(
  parameter int STAGES = MENU_MAX_LEN,
  parameter int NUM_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              load_i,
  input logic [MODE_W-1:0] mode_q,
  input logic [STAGES-1:0] state_q,
  input logic [NUM_W-1:0]  num_o,
  input logic              wrap_o
);

  // R9
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R10
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q & ~STAGES'(len_mask(mode_q))) == '0);

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load_i) |=> $stable(state_q));

  // R8
  wrap_source_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> $past(en_i && !load_i));

  // R2
  fib_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !load_i && prbs_mode_e'(mode_q) != MODE_GAL8) |=> num_o[6:0] == $past(num_o[7:1]));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(mode_q));

endmodule

bind prbs_multi_gen prbs_multi_gen_chk #(.STAGES(STAGES), .NUM_W(NUM_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_i    (en_i),
  .load_i  (load_i),
  .mode_q  (mode_q),
  .state_q (state_q),
  .num_o   (num_o),
  .wrap_o  (wrap_o)
);

// File: tb/prbs_multi_gen_bench.sv
module prbs_multi_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic        load_i = 1'b0;
  logic [2:0]  mode_i = 3'd1;
  logic [22:0] seed_i = '0;
  logic        bit_o;
  logic [8:0]  num_o;
  logic        wrap_o;

  int errors = 0;
  int checks = 0;

  logic [22:0] m_state;
  logic [22:0] m_seed;
  logic [2:0]  m_mode;
  logic        m_wrap;

  prbs_multi_gen u_prbs_multi_gen (
    .clk(clk), .rst(rst), .en_i(en_i), .load_i(load_i), .mode_i(mode_i),
    .seed_i(seed_i), .bit_o(bit_o), .num_o(num_o), .wrap_o(wrap_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_len(logic [2:0] m);
    case (m)
      3'd0: return 8;
      3'd2: return 15;
      3'd3: return 16;
      3'd4: return 20;
      3'd5: return 21;
      3'd6: return 23;
      default: return 9;
    endcase
  endfunction

  function automatic logic [22:0] ref_ones(logic [2:0] m);
    return 23'((64'd1 << ref_len(m)) - 64'd1);
  endfunction

  function automatic logic [22:0] ref_next(logic [22:0] s, logic [2:0] m);
    logic [22:0] n;
    n = s >> 1;
    case (m)
      3'd0: if (s[0]) n = n ^ 23'h0000B8;
      3'd2: n[14] = s[1] ^ s[0];
      3'd3: n[15] = s[5] ^ s[3] ^ s[2] ^ s[0];
      3'd4: n[19] = s[3] ^ s[0];
      3'd5: n[20] = s[2] ^ s[0];
      3'd6: n[22] = s[5] ^ s[0];
      default: n[8] = s[4] ^ s[0];
    endcase
    return n;
  endfunction

  function automatic logic [8:0] ref_num(logic [22:0] s, logic [2:0] m);
    logic ninth;
    ninth = (m == 3'd1 || m == 3'd7) ? s[8] : 1'b0;
    return {ninth, s[7:0]};
  endfunction

  task automatic compare(input string tag);
    logic [8:0] en_num;
    en_num = ref_num(m_state, m_mode);
    checks++;
    if (bit_o !== m_state[0] || num_o !== en_num || wrap_o !== m_wrap) begin
      errors++;
      $display("FAIL %s: bit=%b num=%h wrap=%b expected bit=%b num=%h wrap=%b",
               tag, bit_o, num_o, wrap_o, m_state[0], en_num, m_wrap);
    end
  endtask

  task automatic cycle(input logic rs, input logic e, input logic l,
                       input logic [2:0] md, input logic [22:0] sd, input string tag);
    logic [22:0] cut;
    rst = rs; en_i = e; load_i = l; mode_i = md; seed_i = sd;
    @(posedge clk);
    if (rs) begin
      m_mode = md; m_state = ref_ones(md); m_seed = m_state; m_wrap = 1'b0;
    end else if (l) begin
      m_mode = md;
      cut = sd & ref_ones(md);
      m_state = (cut == '0) ? ref_ones(md) : cut;
      m_seed = m_state; m_wrap = 1'b0;
    end else if (e) begin
      m_state = ref_next(m_state, m_mode);
      m_wrap = (m_state == m_seed);
    end else begin
      m_wrap = 1'b0;
    end
    #(CLK_PERIOD/4);
    compare(tag);
  endtask

  task automatic run_period(input logic [2:0] md, input int period, input string tag);
    int early;
    int hit;
    early = 0; hit = 0;
    cycle(1'b0, 1'b0, 1'b1, md, 23'h000001, tag);
    en_i = 1'b1; load_i = 1'b0;
    for (int i = 1; i <= period; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (i < period && wrap_o) early++;
      if (i == period) hit = wrap_o;
    end
    en_i = 1'b0;
    checks++;
    if (early != 0 || hit != 1 || num_o !== 9'h001) begin
      errors++;
      $display("FAIL %s: early=%0d final_wrap=%0d num=%h expected early=0 final_wrap=1 num=001",
               tag, early, hit, num_o);
    end
    m_state = 23'h000001; m_seed = 23'h000001; m_mode = md; m_wrap = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd20240917);
    m_state = '0; m_seed = '0; m_mode = '0; m_wrap = 1'b0;

    // R1 reset in 9-stage mode and in Galois mode
    cycle(1'b1, 1'b0, 1'b0, 3'd1, 23'h0, "R1 reset mode1");
    cycle(1'b1, 1'b1, 1'b1, 3'd1, 23'h12, "R1 reset mode1 again");
    cycle(1'b1, 1'b0, 1'b0, 3'd0, 23'h0, "R1 reset mode0");

    // R4 hold while idle, mode_i wiggling (R6)
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0, 3'(i + 2), 23'h55, "R4 R6 idle hold");

    // R3 Galois steps from seed 1
    cycle(1'b0, 1'b0, 1'b1, 3'd0, 23'h000001, "R5 load galois");
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b1, 1'b0, 3'd0, 23'h0, "R3 galois step");

    // R5 R9 zero seed and seed zero after masking
    cycle(1'b0, 1'b0, 1'b1, 3'd3, 23'h000000, "R5 R9 zero seed mode3");
    cycle(1'b0, 1'b0, 1'b1, 3'd1, 23'h7FFE00, "R5 R9 masked-zero seed mode1");
    // R5 load wins over enable
    cycle(1'b0, 1'b1, 1'b1, 3'd2, 23'h001234, "R5 load priority");

    // R10 R7 long seed into 9-stage mode, then steps
    cycle(1'b0, 1'b0, 1'b1, 3'd6, 23'h7FFFFF, "R10 load mode6");
    cycle(1'b0, 1'b0, 1'b1, 3'd1, 23'h7FFFFF, "R10 load mode1");
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 1'b0, 3'd6, 23'h0, "R10 R7 R2 mode1 steps");
    // R7 reserved code behaves as 9-stage, ninth bit shown
    cycle(1'b0, 1'b0, 1'b1, 3'd7, 23'h000100, "R7 reserved load");
    for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1, 1'b0, 3'd0, 23'h0, "R7 R2 reserved steps");

    // R8 full periods
    run_period(3'd0, 255, "R8 R3 period galois");
    run_period(3'd1, 511, "R8 R2 period 9");
    run_period(3'd2, 32767, "R8 R2 period 15");
    run_period(3'd3, 65535, "R8 R2 period 16");

    // random mix: R2 R4 R5 R6 R7 R9
    cycle(1'b0, 1'b0, 1'b1, 3'd4, 23'h0ABCDE, "R5 load mode4");
    for (int i = 0; i < 6000; i++) begin
      logic rs, e, l;
      logic [2:0] md;
      logic [22:0] sd;
      rs = ($urandom % 300) == 0;
      l  = ($urandom % 25) == 0;
      e  = ($urandom % 4) != 0;
      md = 3'($urandom % 8);
      sd = (($urandom % 8) == 0) ? 23'h0 : 23'($urandom);
      cycle(rs, e, l, md, sd, "R2 R4 R5 R6 R7 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule